// File: doc/BRIEF.md
# Two-Pin Shared Port Controller

This block owns two package pins that can serve either as plain general-purpose I/O or as the pins of a serial audio transmitter. Software sets each pin to one of four modes: disconnected, GPIO input, GPIO output, or peripheral function. It does this through a control register and a direction register on a simple register bus. A third register holds the GPIO output values and returns the pin levels when read.

For pin i, the mode code is the pair {direction bit i, control bit i}. In peripheral mode, pin 0 becomes the transmitter's audio clock input and pin 1 becomes its serial data output. The transmitter is held in its own reset unless at least one pin is in peripheral mode. That way, software enables the peripheral simply by handing it a pin.

Top module: `dual_pin_port`

## Requirements
- R1: After the synchronous reset `rst`, the control, direction and data registers read zero, both `pad_oe` bits are 0, and `per_rst` is 1.
- R2: The mode of pin i is the code {dir[i], ctrl[i]}: 00 disconnected, 01 GPIO input, 10 GPIO output, 11 peripheral. `pad_oe[i]` is 1 only for 10, and for 11 on pin 1 only; pin 0 in mode 11 is never driven.
- R3: `pad_out[i]` equals data register bit i in mode 10, equals `per_data_out` for pin 1 in mode 11, and is 0 in every other case.
- R4: When pin 0 is in mode 11, `per_clk_in` follows `pad_in[0]` delayed by exactly two clock edges; in any other mode of pin 0, `per_clk_in` is 0.
- R5: `per_rst` is 0 exactly while at least one pin is in mode 11, and 1 otherwise.
- R6: The registers are 24 bits wide with only bits 1:0 implemented (bit i belongs to pin i). Bits 23:2 read as zero, and writes to them leave the implemented bits untouched.
- R7: The control register is at address 0xD7, the direction register at 0xD6, and the data register at 0xD5. A read of any other address returns zero.
- R8: A one-cycle pulse on `soft_rst` clears the control and direction registers, so both pins become disconnected and `per_rst` returns to 1.
- R9: A data-register read returns, per bit: the two-flop synchronized pad level for a pin in mode 01, the register bit for a pin in mode 10, and 0 for a pin in mode 00 or 11.
- R10: A write presented with `bus_we` takes effect on the next rising clock edge, and the pin outputs and `per_rst` change right after that edge, not before it. A read presented with `bus_re` returns its data on `bus_rdata` after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Synchronous software reset of the mode registers |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Registered read data |
| pad_in | input | 2 | Pad input levels |
| pad_oe | output | 2 | Pad output enables |
| pad_out | output | 2 | Pad output data |
| per_data_out | input | 1 | Serial data from the audio transmitter |
| per_clk_in | output | 1 | Synchronized audio clock toward the transmitter |
| per_rst | output | 1 | Transmitter reset, active high |

## Verification
The mode decoder is driven through several register pairs. Each pair puts the two pins in different modes at the same time: output next to disconnected, peripheral next to input, and peripheral on both pins. This shows that each pin decodes only its own bits, and that pin 0 and pin 1 treat peripheral mode differently. The pad inputs are set so that they disagree with the data register. A read of the data register therefore shows whether a pin reports its level, its stored value, or the forced zero. Writes that carry ones only in the upper bits confirm that those bits reach no state. Outputs sampled just before and just after a write's edge pin down when the change takes effect. Pad-level changes observed on the peripheral clock output pin down the two-stage delay.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;
  typedef enum logic [1:0] {
    PM_OFF = 2'b00,
    PM_IN  = 2'b01,
    PM_OUT = 2'b10,
    PM_ALT = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/port_regs.sv
module port_regs #(
  parameter int REG_W = 24,
  parameter int PINS = 2,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hD7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [PINS-1:0]   rd_view,
  output logic [PINS-1:0]   ctrl_q,
  output logic [PINS-1:0]   dir_q,
  output logic [PINS-1:0]   data_q,
  output logic [REG_W-1:0]  bus_rdata
);
  localparam logic [ADDR_W-1:0] DIR_ADDR  = CTRL_ADDR - 1'b1;
  localparam logic [ADDR_W-1:0] DATA_ADDR = CTRL_ADDR - 2'd2;
  localparam int PAD_W = REG_W - PINS;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[REG_W-1:PINS];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      dir_q  <= '0;
    end else if (soft_rst) begin
      ctrl_q <= '0;
      dir_q  <= '0;
    end else if (bus_we) begin
      if (bus_addr == CTRL_ADDR) ctrl_q <= bus_wdata[PINS-1:0];
      if (bus_addr == DIR_ADDR)  dir_q  <= bus_wdata[PINS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else if (bus_we && bus_addr == DATA_ADDR) data_q <= bus_wdata[PINS-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      bus_rdata <= '0;
      if (bus_addr == CTRL_ADDR)      bus_rdata <= {{PAD_W{1'b0}}, ctrl_q};
      else if (bus_addr == DIR_ADDR)  bus_rdata <= {{PAD_W{1'b0}}, dir_q};
      else if (bus_addr == DATA_ADDR) bus_rdata <= {{PAD_W{1'b0}}, rd_view};
    end
  end
endmodule

// File: rtl/pad_sync.sv
module pad_sync #(
  parameter int PINS = 2,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] d,
  output logic [PINS-1:0] q
);
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/pin_mux.sv
module pin_mux
  import pin_port_pkg::*;
#(
  parameter int PINS = 2,
  parameter int CLK_PIN = 0,
  parameter int DOUT_PIN = 1
) (
  input  logic [PINS-1:0] ctrl_q,
  input  logic [PINS-1:0] dir_q,
  input  logic [PINS-1:0] data_q,
  input  logic [PINS-1:0] lvl_sync,
  input  logic            per_data_out,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] rd_view,
  output logic            per_clk_in,
  output logic            per_rst
);
  logic [PINS-1:0] alt;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    pin_mode_e mode;
    assign mode = pin_mode_e'({dir_q[i], ctrl_q[i]});
    always_comb begin
      pad_oe[i]  = 1'b0;
      pad_out[i] = 1'b0;
      rd_view[i] = 1'b0;
      alt[i]     = 1'b0;
      case (mode)
        PM_IN:  rd_view[i] = lvl_sync[i];
        PM_OUT: begin
          pad_oe[i]  = 1'b1;
          pad_out[i] = data_q[i];
          rd_view[i] = data_q[i];
        end
        PM_ALT: begin
          alt[i] = 1'b1;
          if (i == DOUT_PIN) begin
            pad_oe[i]  = 1'b1;
            pad_out[i] = per_data_out;
          end
        end
        default: ;
      endcase
    end
  end

  assign per_clk_in = alt[CLK_PIN] & lvl_sync[CLK_PIN];
  assign per_rst    = ~|alt;
endmodule

// File: rtl/dual_pin_port.sv
module dual_pin_port #(
  parameter int REG_W = 24,
  parameter int PINS = 2,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hD7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_out,
  input  logic              per_data_out,
  output logic              per_clk_in,
  output logic              per_rst
);
  logic [PINS-1:0] ctrl_q, dir_q, data_q, lvl_sync, rd_view;

  pad_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(lvl_sync)
  );

  port_regs #(.REG_W(REG_W), .PINS(PINS), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_view(rd_view),
    .ctrl_q(ctrl_q), .dir_q(dir_q), .data_q(data_q), .bus_rdata(bus_rdata)
  );

  pin_mux #(.PINS(PINS), .CLK_PIN(0), .DOUT_PIN(1)) u_mux (
    .ctrl_q(ctrl_q), .dir_q(dir_q), .data_q(data_q), .lvl_sync(lvl_sync),
    .per_data_out(per_data_out), .pad_oe(pad_oe), .pad_out(pad_out),
    .rd_view(rd_view), .per_clk_in(per_clk_in), .per_rst(per_rst)
  );
endmodule

// File: rtl/dual_pin_port_chk.sv
module dual_pin_port_chk #(
  parameter int REG_W = 24,
  parameter int PINS = 2,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hD7
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              pad0_in,
  input logic [PINS-1:0]   pad_oe,
  input logic              per_rst,
  input logic              per_clk_in,
  input logic [PINS-1:0]   ctrl_q,
  input logic [PINS-1:0]   dir_q
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pad_oe == '0 && per_rst));

  assert_soft_clear_R8: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (pad_oe == '0 && per_rst));

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[REG_W-1:PINS] == '0);

  assert_write_lands_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == CTRL_ADDR && !soft_rst) |=> ctrl_q == $past(bus_wdata[PINS-1:0]));

  assert_clk_delay_R4: assert property (@(posedge clk) disable iff (rst)
    ({dir_q[0], ctrl_q[0]} == 2'b11 && !$past(rst) && !$past(rst, 2))
      |-> per_clk_in == $past(pad0_in, 2));

  assert_alt_release_R5: assert property (@(posedge clk) disable iff (rst)
    ((ctrl_q & dir_q) != '0) |-> !per_rst);

  assert_clk_pin_hiz_R2: assert property (@(posedge clk) disable iff (rst)
    ({dir_q[0], ctrl_q[0]} == 2'b11) |-> !pad_oe[0]);
endmodule

bind dual_pin_port dual_pin_port_chk #(
  .REG_W(REG_W), .PINS(PINS), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad0_in(pad_in[0]), .pad_oe(pad_oe),
  .per_rst(per_rst), .per_clk_in(per_clk_in), .ctrl_q(ctrl_q), .dir_q(dir_q)
);

// File: tb/test_dual_pin_port.sv
`timescale 1ns/1ps
module test_dual_pin_port;
  localparam logic [7:0] A_CTRL = 8'hD7;
  localparam logic [7:0] A_DIR  = 8'hD6;
  localparam logic [7:0] A_DATA = 8'hD5;
  localparam int S_OE = 0, S_OUT = 1, S_RST = 2, S_CLK = 3, S_RD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic soft_rst = 1'b0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [23:0] bus_wdata = '0;
  logic [23:0] bus_rdata;
  logic [1:0] pad_in = '0, pad_oe, pad_out;
  logic per_data_out = 1'b0, per_clk_in, per_rst;

  always #2.5 clk = ~clk;

  dual_pin_port i_dual_pin_port (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .per_data_out(per_data_out), .per_clk_in(per_clk_in), .per_rst(per_rst)
  );

  typedef struct {
    string       tag;
    int          sel;
    logic [23:0] exp;
  } item_t;

  item_t sb_q[$];
  event  sb_ev;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  function automatic logic [23:0] actual(int sel);
    case (sel)
      S_OE:    return {22'd0, pad_oe};
      S_OUT:   return {22'd0, pad_out};
      S_RST:   return {23'd0, per_rst};
      S_CLK:   return {23'd0, per_clk_in};
      default: return bus_rdata;
    endcase
  endfunction

  // monitor: pops expected items and compares against the live outputs
  initial forever begin
    @(sb_ev);
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (actual(it.sel) !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %0h expected %0h", it.tag, actual(it.sel), it.exp);
      end
    end
  end

  task automatic expect_val(string tag, int sel, logic [23:0] exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
    -> sb_ev;
    #0.1;
  endtask

  task automatic wr(logic [7:0] a, logic [23:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [23:0] exp);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    expect_val(tag, S_RD, exp);
  endtask

  task automatic pads(logic [1:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_val("R1 oe after reset", S_OE, 24'h0);
    expect_val("R1 per_rst after reset", S_RST, 24'h1);
    rd_chk("R1 ctrl after reset", A_CTRL, 24'h0);
    rd_chk("R1 data after reset", A_DATA, 24'h0);

    // pin0 GPIO output (10), pin1 disconnected (00)
    wr(A_DIR, 24'h1);
    wr(A_DATA, 24'h1);
    expect_val("R2 pin0 output oe", S_OE, 24'h1);
    expect_val("R3 pin0 output data", S_OUT, 24'h1);
    expect_val("R5 no alt keeps reset", S_RST, 24'h1);
    rd_chk("R7 dir at ctrl-1", A_DIR, 24'h1);

    // ctrl all ones: pin0 -> 11 (alt clock), pin1 -> 01 (input)
    wr(A_CTRL, 24'hFFFFFF);
    rd_chk("R6 ctrl upper bits zero", A_CTRL, 24'h3);
    expect_val("R5 alt on pin0 releases reset", S_RST, 24'h0);
    expect_val("R2 alt clock pin undriven", S_OE, 24'h0);
    pads(2'b01);
    expect_val("R4 clock follows pad", S_CLK, 24'h1);
    @(negedge clk);
    pad_in = 2'b10;
    @(negedge clk);
    expect_val("R4 clock still old after one edge", S_CLK, 24'h1);
    @(negedge clk);
    expect_val("R4 clock new after two edges", S_CLK, 24'h0);
    rd_chk("R9 input reads pad, alt reads zero", A_DATA, 24'h2);

    // both pins alt
    wr(A_DIR, 24'h3);
    per_data_out = 1'b1;
    #0.5;
    expect_val("R2 pin1 alt drives", S_OE, 24'h2);
    expect_val("R3 pin1 carries peripheral data", S_OUT, 24'h2);
    per_data_out = 1'b0;
    #0.5;
    expect_val("R3 pin1 peripheral data low", S_OUT, 24'h0);

    // upper-only write to dir: dir becomes 00, pins 01 input
    wr(A_DIR, 24'hFFFFFC);
    rd_chk("R6 upper-only write clears dir", A_DIR, 24'h0);
    expect_val("R5 no alt re-asserts reset", S_RST, 24'h1);
    expect_val("R4 clock zero out of alt", S_CLK, 24'h0);
    expect_val("R2 inputs undriven", S_OE, 24'h0);

    // pin0 disconnected, pin1 output
    wr(A_CTRL, 24'h0);
    wr(A_DIR, 24'h2);
    wr(A_DATA, 24'h3);
    pads(2'b01);
    rd_chk("R9 disconnected masked, output reads register", A_DATA, 24'h2);
    expect_val("R3 only output pin carries data", S_OUT, 24'h2);
    rd_chk("R7 unmapped address reads zero", 8'h00, 24'h0);

    // write timing
    @(negedge clk);
    bus_we = 1'b1; bus_addr = A_DIR; bus_wdata = 24'h1;
    #1;
    expect_val("R10 oe unchanged before edge", S_OE, 24'h2);
    @(negedge clk);
    bus_we = 1'b0;
    expect_val("R10 oe updated after edge", S_OE, 24'h1);

    // soft reset
    wr(A_CTRL, 24'h3);
    wr(A_DIR, 24'h3);
    expect_val("R8 alt active before soft reset", S_RST, 24'h0);
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    expect_val("R8 soft reset restores per_rst", S_RST, 24'h1);
    expect_val("R8 soft reset releases pads", S_OE, 24'h0);
    rd_chk("R8 soft reset clears ctrl", A_CTRL, 24'h0);

    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule